// File: doc/BRIEF.md
# Integer Register Bank with Multiply/Divide Result Pair

This block is the integer register storage of a small 32-bit load/store processor core. It holds thirty-two general registers of 32 bits, addressed by a 5-bit index. Two read ports return register contents combinationally so the decode stage can fetch both source operands in one cycle. One synchronous write port retires the single destination result of each instruction. Index zero is wired to zero: it always reads as zero and ignores writes.

A second write path is reserved for subroutine calls. It stores a return address into the top register, index 31. This path is independent of the normal write port, so a call can retire in the same cycle as another result. The bank also keeps a separate HI/LO register pair. Multiply and divide units fill it, either from one 64-bit result word with a single strobe or one half at a time. A multiply sends its 64-bit product, with the upper half going to HI. A divide sends its remainder in the upper half and its quotient in the lower half.

A parameter selects whether a read of a register being written in the same cycle returns the stored (old) value or the value being written.

Top module: `gpr_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every general register, HI and LO are cleared to zero.
- R2: Reading index 0 on either port always returns zero, and a write to index 0 is discarded.
- R3: A normal write (`wr_en` high) to a non-zero index stores `wr_data` at the rising edge. Both read ports then return it from the following cycle.
- R4: With `BYPASS` = 0, a read of a register being written in the current cycle returns the previously stored value until the edge.
- R5: A link write (`link_en` high) stores `link_addr` into register 31 at the rising edge.
- R6: A link write and a normal write to register 31 in the same cycle leave the link value in register 31. A normal write to any other index in that cycle is still performed.
- R7: A pair write (`pair_we` high) loads HI with `pair_data[63:32]` and LO with `pair_data[31:0]` in one edge.
- R8: `hi_we` loads HI from `hi_data` and `lo_we` loads LO from `lo_data`, each leaving the other half unchanged.
- R9: When a single-half strobe and `pair_we` are high in the same cycle, that half takes its single-half data and the other half takes the pair data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 5 | Index for read port A |
| rd_a_data | output | 32 | Combinational data of read port A |
| rd_b_idx | input | 5 | Index for read port B |
| rd_b_data | output | 32 | Combinational data of read port B |
| wr_en | input | 1 | Normal write strobe |
| wr_idx | input | 5 | Normal write index |
| wr_data | input | 32 | Normal write data |
| link_en | input | 1 | Call return-address write strobe |
| link_addr | input | 32 | Return address written to register 31 |
| pair_we | input | 1 | Load HI and LO together |
| pair_data | input | 64 | Upper half to HI, lower half to LO |
| hi_we | input | 1 | Load HI alone |
| hi_data | input | 32 | Data for HI alone |
| lo_we | input | 1 | Load LO alone |
| lo_data | input | 32 | Data for LO alone |
| hi_q | output | 32 | Current HI value |
| lo_q | output | 32 | Current LO value |

## Verification
Two pairs of functions can fall in the same cycle. The first is a call's link write arriving together with a normal write. The second is a pair load of HI/LO arriving together with a single-half strobe. The bench forces each collision deliberately: a normal write to register 31 and to a different register alongside a link write, and a pair load alongside a HI-only and a LO-only strobe. It then reads back through the ports on the next cycle and compares against a shadow model built from the priority rules. Before any of that, a full sweep writes and reads every index on both ports, including the discarded write to index zero.

// File: rtl/gpr_pkg.sv
// Package: shared defaults for the integer register bank.
// Assumes the register count is a power of two.
package gpr_pkg;
    parameter int unsigned GPR_XLEN  = 32;
    parameter int unsigned GPR_COUNT = 32;

    // Selects how a same-cycle read of a written register is resolved
    typedef enum logic {
        READ_OLD = 1'b0,
        READ_NEW = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/gpr_write_arb.sv
// Module: resolves the normal write port against the call link path.
// Drops writes to index zero and drops a normal write to the link
// register when a link write lands in the same cycle.
// Assumes LINK_IDX is non-zero.
module gpr_write_arb #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned AW       = 5,
    parameter logic [AW-1:0] LINK_IDX = '1
) (
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic            link_en,
    input  logic [XLEN-1:0] link_addr,
    output logic            norm_go,
    output logic [AW-1:0]   norm_idx,
    output logic [XLEN-1:0] norm_data,
    output logic            link_go,
    output logic [XLEN-1:0] link_data
);
    logic idx_is_zero;
    logic link_clash;

    // Detect the two cases that suppress a normal write
    always_comb begin
        idx_is_zero = (wr_idx == '0);
        link_clash  = link_en && (wr_idx == LINK_IDX);
    end

    // Forward the surviving requests to the storage array
    always_comb begin
        norm_go   = wr_en && !idx_is_zero && !link_clash;
        norm_idx  = wr_idx;
        norm_data = wr_data;
        link_go   = link_en;
        link_data = link_addr;
    end
endmodule

// File: rtl/gpr_storage.sv
// Module: array of general registers with a hardwired zero entry.
// Each entry has its own flop group. The link path has priority on
// the link entry. Inputs are assumed pre-filtered by gpr_write_arb.
module gpr_storage #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NREGS    = 32,
    parameter int unsigned AW       = 5,
    parameter logic [AW-1:0] LINK_IDX = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            norm_go,
    input  logic [AW-1:0]   norm_idx,
    input  logic [XLEN-1:0] norm_data,
    input  logic            link_go,
    input  logic [XLEN-1:0] link_data,
    output logic [XLEN-1:0] regs [NREGS]
);
    genvar g;
    generate
        for (g = 0; g < NREGS; g++) begin : g_entry
            if (g == 0) begin : g_zero
                // Entry zero is a constant, never stored
                assign regs[g] = '0;
            end else begin : g_flop
                localparam logic [AW-1:0] MY_IDX = AW'(g);
                logic [XLEN-1:0] q;
                logic            hit_link;
                logic            hit_norm;

                // Decode whether either path targets this entry
                always_comb begin
                    hit_link = link_go && (MY_IDX == LINK_IDX);
                    hit_norm = norm_go && (norm_idx == MY_IDX);
                end

                // Update the entry, link path first
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        q <= '0;
                    end else if (hit_link) begin
                        q <= link_data;
                    end else if (hit_norm) begin
                        q <= norm_data;
                    end
                end

                assign regs[g] = q;
            end
        end
    endgenerate
endmodule

// File: rtl/gpr_read_port.sv
// Module: one combinational read port over the register array.
// With BYPASS set, a same-cycle write to the selected entry is
// returned in place of the stored value (link path first).
module gpr_read_port #(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned NREGS    = 32,
    parameter int unsigned AW       = 5,
    parameter logic [AW-1:0] LINK_IDX = '1,
    parameter gpr_pkg::rd_mode_e MODE = gpr_pkg::READ_OLD
) (
    input  logic [AW-1:0]   sel,
    input  logic [XLEN-1:0] regs [NREGS],
    input  logic            norm_go,
    input  logic [AW-1:0]   norm_idx,
    input  logic [XLEN-1:0] norm_data,
    input  logic            link_go,
    input  logic [XLEN-1:0] link_data,
    output logic [XLEN-1:0] data
);
    logic [XLEN-1:0] stored;

    // Pick the stored value of the selected entry
    always_comb begin
        stored = regs[sel];
    end

    generate
        if (MODE == gpr_pkg::READ_NEW) begin : g_bypass
            // Replace stored value with an in-flight write to the same entry
            always_comb begin
                if (sel == '0) begin
                    data = '0;
                end else if (link_go && (sel == LINK_IDX)) begin
                    data = link_data;
                end else if (norm_go && (norm_idx == sel)) begin
                    data = norm_data;
                end else begin
                    data = stored;
                end
            end
        end else begin : g_plain
            logic unused_ok;
            // Old value only; write-side inputs are not consulted
            always_comb begin
                data      = stored;
                unused_ok = ^{norm_go, norm_idx, norm_data, link_go, link_data};
            end
        end
    endgenerate
endmodule

// File: rtl/gpr_hilo.sv
// Module: HI/LO result pair for multiply and divide units.
// A single-half strobe takes priority over the pair load for its half.
module gpr_hilo #(
    parameter int unsigned XLEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_we,
    input  logic [2*XLEN-1:0] pair_data,
    input  logic              hi_we,
    input  logic [XLEN-1:0]   hi_data,
    input  logic              lo_we,
    input  logic [XLEN-1:0]   lo_data,
    output logic [XLEN-1:0]   hi_q,
    output logic [XLEN-1:0]   lo_q
);
    logic [XLEN-1:0] pair_hi;
    logic [XLEN-1:0] pair_lo;

    // Split the wide result into its two halves
    always_comb begin
        pair_hi = pair_data[2*XLEN-1:XLEN];
        pair_lo = pair_data[XLEN-1:0];
    end

    // Update HI: single strobe first, then pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (hi_we) begin
            hi_q <= hi_data;
        end else if (pair_we) begin
            hi_q <= pair_hi;
        end
    end

    // Update LO: single strobe first, then pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
        end else if (lo_we) begin
            lo_q <= lo_data;
        end else if (pair_we) begin
            lo_q <= pair_lo;
        end
    end
endmodule

// File: rtl/gpr_bank.sv
// Module: top of the integer register bank.
// Two combinational read ports, one normal write port, a call link
// path into the top register, and the HI/LO pair.
// Assumes NREGS is a power of two and at least 2.
module gpr_bank #(
    parameter int unsigned XLEN   = gpr_pkg::GPR_XLEN,
    parameter int unsigned NREGS  = gpr_pkg::GPR_COUNT,
    parameter bit          BYPASS = 1'b0,
    localparam int unsigned AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_a_idx,
    output logic [XLEN-1:0]   rd_a_data,
    input  logic [AW-1:0]     rd_b_idx,
    output logic [XLEN-1:0]   rd_b_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              link_en,
    input  logic [XLEN-1:0]   link_addr,
    input  logic              pair_we,
    input  logic [2*XLEN-1:0] pair_data,
    input  logic              hi_we,
    input  logic [XLEN-1:0]   hi_data,
    input  logic              lo_we,
    input  logic [XLEN-1:0]   lo_data,
    output logic [XLEN-1:0]   hi_q,
    output logic [XLEN-1:0]   lo_q
);
    localparam logic [AW-1:0] LINK_IDX = AW'(NREGS - 1);
    localparam int unsigned   NPORTS   = 2;
    localparam gpr_pkg::rd_mode_e MODE =
        BYPASS ? gpr_pkg::READ_NEW : gpr_pkg::READ_OLD;

    logic            norm_go;
    logic [AW-1:0]   norm_idx;
    logic [XLEN-1:0] norm_data;
    logic            link_go;
    logic [XLEN-1:0] link_data;
    logic [XLEN-1:0] regs [NREGS];
    logic [AW-1:0]   port_sel  [NPORTS];
    logic [XLEN-1:0] port_data [NPORTS];

    gpr_write_arb #(
        .XLEN(XLEN), .AW(AW), .LINK_IDX(LINK_IDX)
    ) u_arb (
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .link_en(link_en), .link_addr(link_addr),
        .norm_go(norm_go), .norm_idx(norm_idx), .norm_data(norm_data),
        .link_go(link_go), .link_data(link_data)
    );

    gpr_storage #(
        .XLEN(XLEN), .NREGS(NREGS), .AW(AW), .LINK_IDX(LINK_IDX)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .norm_go(norm_go), .norm_idx(norm_idx), .norm_data(norm_data),
        .link_go(link_go), .link_data(link_data),
        .regs(regs)
    );

    // Gather port selects so the read ports can be generated
    always_comb begin
        port_sel[0] = rd_a_idx;
        port_sel[1] = rd_b_idx;
    end

    genvar p;
    generate
        for (p = 0; p < NPORTS; p++) begin : g_rport
            gpr_read_port #(
                .XLEN(XLEN), .NREGS(NREGS), .AW(AW),
                .LINK_IDX(LINK_IDX), .MODE(MODE)
            ) u_rd (
                .sel(port_sel[p]), .regs(regs),
                .norm_go(norm_go), .norm_idx(norm_idx), .norm_data(norm_data),
                .link_go(link_go), .link_data(link_data),
                .data(port_data[p])
            );
        end
    endgenerate

    // Drive the read outputs from the generated ports
    always_comb begin
        rd_a_data = port_data[0];
        rd_b_data = port_data[1];
    end

    gpr_hilo #(
        .XLEN(XLEN)
    ) u_hilo (
        .clk(clk), .rst_n(rst_n),
        .pair_we(pair_we), .pair_data(pair_data),
        .hi_we(hi_we), .hi_data(hi_data),
        .lo_we(lo_we), .lo_data(lo_data),
        .hi_q(hi_q), .lo_q(lo_q)
    );
endmodule

// File: rtl/gpr_bank_chk.sv
// Module: property checker for gpr_bank, attached by bind below.
module gpr_bank_chk #(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned NREGS  = 32,
    parameter bit          BYPASS = 1'b0,
    localparam int unsigned AW    = $clog2(NREGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     rd_a_idx,
    input logic [XLEN-1:0]   rd_a_data,
    input logic [AW-1:0]     rd_b_idx,
    input logic [XLEN-1:0]   rd_b_data,
    input logic              wr_en,
    input logic [AW-1:0]     wr_idx,
    input logic [XLEN-1:0]   wr_data,
    input logic              link_en,
    input logic [XLEN-1:0]   link_addr,
    input logic              pair_we,
    input logic [2*XLEN-1:0] pair_data,
    input logic              hi_we,
    input logic [XLEN-1:0]   hi_data,
    input logic              lo_we,
    input logic [XLEN-1:0]   lo_data,
    input logic [XLEN-1:0]   hi_q,
    input logic [XLEN-1:0]   lo_q
);
    localparam logic [AW-1:0] LINK_IDX = AW'(NREGS - 1);

    // R2
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_a_idx == '0) |-> (rd_a_data == '0)) and
        ((rd_b_idx == '0) |-> (rd_b_data == '0)));

    // R3
    write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx != '0) && !(link_en && (wr_idx == LINK_IDX)))
        |=> ((rd_b_idx != $past(wr_idx)) || BYPASS ||
             (rd_b_data == $past(wr_data))));

    // R5
    link_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |=> ((rd_a_idx != LINK_IDX) || BYPASS ||
                     (rd_a_data == $past(link_addr))));

    // R7
    pair_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_we && !hi_we && !lo_we)
        |=> ((hi_q == $past(pair_data[2*XLEN-1:XLEN])) &&
             (lo_q == $past(pair_data[XLEN-1:0]))));

    // R8
    hi_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !lo_we && !pair_we)
        |=> ((hi_q == $past(hi_data)) && $stable(lo_q)));

    // R8
    lo_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we && !hi_we && !pair_we)
        |=> ((lo_q == $past(lo_data)) && $stable(hi_q)));

    // R9
    half_over_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_we && hi_we && !lo_we)
        |=> ((hi_q == $past(hi_data)) &&
             (lo_q == $past(pair_data[XLEN-1:0]))));
endmodule

bind gpr_bank gpr_bank_chk #(
    .XLEN(XLEN), .NREGS(NREGS), .BYPASS(BYPASS)
) u_gpr_bank_chk (.*);

// File: tb/test_gpr_bank.sv
// Bench for gpr_bank with default parameters (old-value reads).
module test_gpr_bank;
    localparam int XW = 32;
    localparam int NR = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [XW-1:0] rd_a_data, rd_b_data, wr_data = '0, link_addr = '0;
    logic          wr_en = 1'b0, link_en = 1'b0, pair_we = 1'b0;
    logic          hi_we = 1'b0, lo_we = 1'b0;
    logic [2*XW-1:0] pair_data = '0;
    logic [XW-1:0] hi_data = '0, lo_data = '0, hi_q, lo_q;

    int total = 0;
    int bad = 0;
    logic [XW-1:0] shadow [NR];
    logic [XW-1:0] exp_hi, exp_lo;

    always #5 clk = ~clk;

    gpr_bank i_gpr_bank (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .link_en(link_en), .link_addr(link_addr),
        .pair_we(pair_we), .pair_data(pair_data),
        .hi_we(hi_we), .hi_data(hi_data),
        .lo_we(lo_we), .lo_data(lo_data),
        .hi_q(hi_q), .lo_q(lo_q)
    );

    task automatic chk(input string req, input logic [XW-1:0] act,
                       input logic [XW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change only right after the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; link_en = 0; pair_we = 0; hi_we = 0; lo_we = 0;
    endtask

    // Read every index on both ports and compare with the shadow copy
    task automatic sweep_read(input string req);
        for (int i = 0; i < NR; i++) begin
            rd_a_idx = 5'(i);
            rd_b_idx = 5'(NR - 1 - i);
            #1;
            chk(req, rd_a_data, shadow[i]);
            chk(req, rd_b_data, shadow[NR - 1 - i]);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // Dirty the bank before reset so the clear is visible (R1)
        @(negedge clk);
        rst_n = 1;
        wr_en = 1; wr_idx = 5'd9; wr_data = 32'hDEAD_BEEF;
        pair_we = 1; pair_data = 64'h1111_2222_3333_4444;
        step();
        idle();
        rst_n = 0;
        step();
        step();
        rst_n = 1;
        for (int i = 0; i < NR; i++) shadow[i] = '0;
        exp_hi = '0; exp_lo = '0;
        // R1: all cleared after reset
        sweep_read("R1");
        chk("R1", hi_q, exp_hi);
        chk("R1", lo_q, exp_lo);

        // R2/R3: write every index with a computed pattern, index 0 included
        for (int i = 0; i < NR; i++) begin
            wr_en = 1; wr_idx = 5'(i);
            wr_data = 32'h9E37_79B9 * 32'(i + 1);
            if (i != 0) shadow[i] = wr_data;
            step();
        end
        idle();
        sweep_read("R3");
        rd_a_idx = 0; rd_b_idx = 0; #1;
        chk("R2", rd_a_data, 32'h0);
        chk("R2", rd_b_data, 32'h0);

        // R3: inverted pattern overwrite
        for (int i = 1; i < NR; i++) begin
            wr_en = 1; wr_idx = 5'(i); wr_data = ~shadow[i];
            shadow[i] = wr_data;
            step();
        end
        idle();
        sweep_read("R3");

        // R4: same-cycle read returns old value, new one after the edge
        wr_en = 1; wr_idx = 5'd5; wr_data = 32'hCAFE_0005;
        rd_a_idx = 5'd5; rd_b_idx = 5'd5; #1;
        chk("R4", rd_a_data, shadow[5]);
        chk("R4", rd_b_data, shadow[5]);
        shadow[5] = 32'hCAFE_0005;
        step();
        idle(); #1;
        chk("R4", rd_a_data, 32'hCAFE_0005);

        // R5: link write alone
        link_en = 1; link_addr = 32'h0040_1230;
        step();
        idle();
        shadow[31] = 32'h0040_1230;
        rd_a_idx = 5'd31; #1;
        chk("R5", rd_a_data, shadow[31]);

        // R6: link and normal to 31 collide, link wins
        link_en = 1; link_addr = 32'h0040_2000;
        wr_en = 1; wr_idx = 5'd31; wr_data = 32'hBAD0_BAD0;
        step();
        idle();
        shadow[31] = 32'h0040_2000;
        rd_a_idx = 5'd31; rd_b_idx = 5'd31; #1;
        chk("R6", rd_a_data, shadow[31]);
        chk("R6", rd_b_data, shadow[31]);

        // R6: link plus normal to another index, both land
        link_en = 1; link_addr = 32'h0040_3000;
        wr_en = 1; wr_idx = 5'd7; wr_data = 32'h7777_0007;
        step();
        idle();
        shadow[31] = 32'h0040_3000;
        shadow[7] = 32'h7777_0007;
        rd_a_idx = 5'd31; rd_b_idx = 5'd7; #1;
        chk("R6", rd_a_data, shadow[31]);
        chk("R6", rd_b_data, shadow[7]);

        // R7: pair loads with several product/quotient patterns
        for (int k = 0; k < 6; k++) begin
            logic [63:0] prod;
            prod = 64'(32'hF000_0001 + 32'(k)) * 64'(32'h8765_4321 ^ 32'(k * 77));
            pair_we = 1; pair_data = prod;
            step();
            idle();
            exp_hi = prod[63:32]; exp_lo = prod[31:0]; #1;
            chk("R7", hi_q, exp_hi);
            chk("R7", lo_q, exp_lo);
        end
        // R7: divide layout, remainder upper, quotient lower
        pair_we = 1; pair_data = {32'd1000 % 32'd7, 32'd1000 / 32'd7};
        step();
        idle();
        exp_hi = 32'd6; exp_lo = 32'd142; #1;
        chk("R7", hi_q, exp_hi);
        chk("R7", lo_q, exp_lo);

        // R8: single-half writes
        hi_we = 1; hi_data = 32'hA5A5_0001;
        step();
        idle();
        exp_hi = 32'hA5A5_0001; #1;
        chk("R8", hi_q, exp_hi);
        chk("R8", lo_q, exp_lo);
        lo_we = 1; lo_data = 32'h5A5A_0002;
        step();
        idle();
        exp_lo = 32'h5A5A_0002; #1;
        chk("R8", hi_q, exp_hi);
        chk("R8", lo_q, exp_lo);

        // R9: single-half strobe beats the pair for its half
        pair_we = 1; pair_data = 64'h0123_4567_89AB_CDEF;
        hi_we = 1; hi_data = 32'hFEED_0009;
        step();
        idle();
        exp_hi = 32'hFEED_0009; exp_lo = 32'h89AB_CDEF; #1;
        chk("R9", hi_q, exp_hi);
        chk("R9", lo_q, exp_lo);
        pair_we = 1; pair_data = 64'hFFFF_0000_1234_5678;
        lo_we = 1; lo_data = 32'h0BAD_F00D;
        step();
        idle();
        exp_hi = 32'hFFFF_0000; exp_lo = 32'h0BAD_F00D; #1;
        chk("R9", hi_q, exp_hi);
        chk("R9", lo_q, exp_lo);

        // HI/LO and general registers stay independent (R3, R8)
        sweep_read("R3");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule